// File: doc/BRIEF.md
# Event Statistics Counter Bank With Frozen Read View

This block keeps a set of event counters for a network port: received frames, checksum failures, short frames, long frames, sent frames and so on. Each counter advances by one in any clock cycle in which its single-cycle event pulse is high. The counters never stop counting. A small word-addressed register port with separate read and write strobes gives software access to a revision word, a scratch word, a command word and one read address per counter.

Two command bits control what software sees. Setting the freeze bit captures every counter into a private copy on the cycle the bit goes from 0 to 1. While the bit stays set, counter reads return that copy and the live counters keep advancing underneath. Clearing the freeze bit makes reads return the live values again. The clear bit is a one-shot command. Writing it as 1 zeroes every live counter and every frozen copy at the same clock edge, and it always reads back as 0. Counter width, counter count, address width, data width, the revision constant and the overflow policy (wrap or hold at maximum) are all parameters.

Top module: `stat_bank`

## Requirements
- R1: After reset, the command word, the scratch word and every counter read as 0.
- R2: Address 0 always reads the REV_ID parameter value. Writes to address 0 have no effect.
- R3: Address 1 is a scratch word. Every bit can be written, and the word reads back as written.
- R4: Counter i is read at address 3+i, zero-extended to DATA_W. It rises by exactly one after each clock cycle in which evt_pulse[i] is high, and holds otherwise.
- R5: With SATURATE=0, a counter wraps modulo 2^CNT_W, so the value after its maximum is 0.
- R6: Writing the command word (address 2) with bit 3 set clears all counters at that clock edge. Bit 3 reads back as 0.
- R7: If a clear write and an event pulse occur in the same cycle, the counter ends at 0.
- R8: Writing bit 2 of the command word as 1 while it is 0 captures every counter value as it stood before that edge. While bit 2 stays 1, counter reads return the captured values and the live counters keep counting. A repeated write of 1 does not capture again.
- R9: Writing bit 2 as 0 releases the freeze. Counter reads then return live values, including events counted during the freeze.
- R10: A clear issued while frozen also sets the captured values to 0.
- R11: Writes to counter addresses have no effect. Reads of unused addresses return 0.
- R12: In the command word only bit 2 holds state and reads back. All other bits read as 0.
- R13: Read data appears on rd_data one clock after rd_en is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_CNT | One event per bit per cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address for the read or write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |

## Verification
A bad counter or a bad frozen copy shows at the ports only when that counter's address is read. The wrong value appears on rd_data one cycle after the read strobe. A frozen copy that drifts shows up as a changed value between two reads inside one freeze window. A clear that misses a counter or a copy shows up as a nonzero value on the very first read after the clear. Wrap errors appear after 2^CNT_W events, so the bench uses an 8-bit counter to reach the wrap point quickly.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // Register word addresses. Counters follow the command word.
   localparam int unsigned ADR_REV  = 0;
   localparam int unsigned ADR_SCR  = 1;
   localparam int unsigned ADR_CMD  = 2;
   localparam int unsigned ADR_CNT0 = 3;

   // Command word bit positions
   localparam int unsigned CMD_FREEZE_BIT = 2;
   localparam int unsigned CMD_CLEAR_BIT  = 3;

   typedef enum logic [2:0] {
      RSEL_REV,
      RSEL_SCR,
      RSEL_CMD,
      RSEL_CNT,
      RSEL_NONE
   } rsel_e;

   function automatic int unsigned map_span(input int unsigned n_cnt);
      return ADR_CNT0 + n_cnt;
   endfunction
endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
   import stat_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              clr_o,
   output logic              cap_o,
   output logic              freeze_o,
   output logic [DATA_W-1:0] scratch_o,
   output logic [DATA_W-1:0] cmd_word_o
);
   logic              wr_cmd;
   logic              wr_scr;
   logic              freeze_q;
   logic              freeze_req;
   logic [DATA_W-1:0] scratch_q;

   assign wr_cmd     = wr_en && (addr == ADDR_W'(ADR_CMD));
   assign wr_scr     = wr_en && (addr == ADDR_W'(ADR_SCR));
   assign freeze_req = wr_data[CMD_FREEZE_BIT];

   // The clear is a one-cycle pulse taken straight from the write, so it never holds state.
   assign clr_o = wr_cmd && wr_data[CMD_CLEAR_BIT];
   // A capture happens only when the freeze bit goes from 0 to 1.
   assign cap_o = wr_cmd && freeze_req && !freeze_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freeze_q <= 1'b0;
      end else if (wr_cmd) begin
         freeze_q <= freeze_req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scratch_q <= '0;
      end else if (wr_scr) begin
         scratch_q <= wr_data;
      end
   end

   always_comb begin
      cmd_word_o                 = '0;
      cmd_word_o[CMD_FREEZE_BIT] = freeze_q;
   end

   assign freeze_o  = freeze_q;
   assign scratch_o = scratch_q;
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int unsigned CNT_W    = 32,
   parameter bit          SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             cap,
   output logic [CNT_W-1:0] live_o,
   output logic [CNT_W-1:0] snap_o
);
   logic [CNT_W-1:0] live_q;
   logic [CNT_W-1:0] snap_q;
   logic [CNT_W-1:0] live_nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb live_nxt = (&live_q) ? live_q : live_q + CNT_W'(1);
      end else begin : g_wrap
         always_comb live_nxt = live_q + CNT_W'(1);
      end
   endgenerate

   // A clear takes priority over an event in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (clr) begin
         live_q <= '0;
      end else if (inc) begin
         live_q <= live_nxt;
      end
   end

   // A clear also empties the frozen copy, even while it is being captured.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (clr) begin
         snap_q <= '0;
      end else if (cap) begin
         snap_q <= live_q;
      end
   end

   assign live_o = live_q;
   assign snap_o = snap_q;
endmodule

// File: rtl/stat_rdpath.sv
module stat_rdpath
   import stat_pkg::*;
#(
   parameter int unsigned       NUM_CNT = 5,
   parameter int unsigned       CNT_W   = 32,
   parameter int unsigned       ADDR_W  = 4,
   parameter int unsigned       DATA_W  = 32,
   parameter logic [DATA_W-1:0] REV_ID  = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        scratch,
   input  logic [DATA_W-1:0]        cmd_word,
   input  logic                     freeze,
   input  logic [NUM_CNT*CNT_W-1:0] live_flat,
   input  logic [NUM_CNT*CNT_W-1:0] snap_flat,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int unsigned IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

   logic [DATA_W-1:0] cnt_view [NUM_CNT];
   rsel_e             sel;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] rd_nxt;
   logic [DATA_W-1:0] rd_q;

   // Each counter read shows either its live value or its frozen copy.
   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_view
         assign cnt_view[g] = freeze ? DATA_W'(snap_flat[g*CNT_W +: CNT_W])
                                     : DATA_W'(live_flat[g*CNT_W +: CNT_W]);
      end
   endgenerate

   always_comb begin
      sel = RSEL_NONE;
      idx = '0;
      if (addr == ADDR_W'(ADR_REV)) begin
         sel = RSEL_REV;
      end else if (addr == ADDR_W'(ADR_SCR)) begin
         sel = RSEL_SCR;
      end else if (addr == ADDR_W'(ADR_CMD)) begin
         sel = RSEL_CMD;
      end else begin
         for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(ADR_CNT0 + i)) begin
               sel = RSEL_CNT;
               idx = IDX_W'(i);
            end
         end
      end
   end

   always_comb begin
      case (sel)
         RSEL_REV: rd_nxt = REV_ID;
         RSEL_SCR: rd_nxt = scratch;
         RSEL_CMD: rd_nxt = cmd_word;
         RSEL_CNT: rd_nxt = cnt_view[idx];
         default:  rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= rd_nxt;
      end
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/stat_bank.sv
module stat_bank
   import stat_pkg::*;
#(
   parameter int unsigned       NUM_CNT  = 5,
   parameter int unsigned       CNT_W    = 32,
   parameter int unsigned       ADDR_W   = 4,
   parameter int unsigned       DATA_W   = 32,
   parameter bit                SATURATE = 1'b0,
   parameter logic [DATA_W-1:0] REV_ID   = DATA_W'(32'h0001_0300)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CNT-1:0] evt_pulse,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int unsigned FLAT_W = NUM_CNT * CNT_W;

   generate
      if (NUM_CNT < 1) begin : g_chk_num
         $error("stat_bank: NUM_CNT must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_chk_cw
         $error("stat_bank: CNT_W must lie in 1..DATA_W");
      end
      if (DATA_W <= CMD_CLEAR_BIT) begin : g_chk_dw
         $error("stat_bank: DATA_W too narrow for the command word");
      end
      if (map_span(NUM_CNT) > (1 << ADDR_W)) begin : g_chk_aw
         $error("stat_bank: ADDR_W too small for the register map");
      end
   endgenerate

   logic              clr;
   logic              cap;
   logic              freeze;
   logic [DATA_W-1:0] scratch;
   logic [DATA_W-1:0] cmd_word;
   logic [FLAT_W-1:0] live_flat;
   logic [FLAT_W-1:0] snap_flat;

   stat_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .clr_o      (clr),
      .cap_o      (cap),
      .freeze_o   (freeze),
      .scratch_o  (scratch),
      .cmd_word_o (cmd_word)
   );

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
         stat_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .inc    (evt_pulse[g]),
            .cap    (cap),
            .live_o (live_flat[g*CNT_W +: CNT_W]),
            .snap_o (snap_flat[g*CNT_W +: CNT_W])
         );
      end
   endgenerate

   stat_rdpath #(
      .NUM_CNT (NUM_CNT),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REV_ID  (REV_ID)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .addr      (addr),
      .scratch   (scratch),
      .cmd_word  (cmd_word),
      .freeze    (freeze),
      .live_flat (live_flat),
      .snap_flat (snap_flat),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
   import stat_pkg::*;
#(
   parameter int unsigned       NUM_CNT  = 5,
   parameter int unsigned       CNT_W    = 32,
   parameter int unsigned       ADDR_W   = 4,
   parameter int unsigned       DATA_W   = 32,
   parameter bit                SATURATE = 1'b0,
   parameter logic [DATA_W-1:0] REV_ID   = '0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CNT-1:0]       evt_pulse,
   input logic                     wr_en,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        addr,
   input logic [DATA_W-1:0]        wr_data,
   input logic [DATA_W-1:0]        rd_data,
   input logic [NUM_CNT*CNT_W-1:0] live_flat,
   input logic [NUM_CNT*CNT_W-1:0] snap_flat,
   input logic                     freeze
);
   logic wr_cmd_c;
   logic clr_c;
   assign wr_cmd_c = wr_en && (addr == ADDR_W'(ADR_CMD));
   assign clr_c    = wr_cmd_c && wr_data[CMD_CLEAR_BIT];

   // R2: the revision word is constant
   p_rev_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(ADR_REV)) |=> (rd_data == REV_ID));

   // R3: scratch data written and then read back
   p_scratch_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADR_SCR)) ##1 (rd_en && !wr_en && addr == ADDR_W'(ADR_SCR))
      |=> (rd_data == $past(wr_data, 2)));

   // R6, R7, R10: a clear leaves both the live values and the copies at zero
   p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c |=> (live_flat == '0 && snap_flat == '0));

   // R8: the frozen copies hold while the command word is left alone
   p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_cmd_c) |=> $stable(snap_flat));

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
         // R4: no event, no clear, no change
         p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_c && !evt_pulse[i]) |=> $stable(live_flat[i*CNT_W +: CNT_W]));
         if (!SATURATE) begin : g_wrap
            // R4, R5: one step per event, modulo 2^CNT_W
            p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (!clr_c && evt_pulse[i]) |=>
               (live_flat[i*CNT_W +: CNT_W] == CNT_W'($past(live_flat[i*CNT_W +: CNT_W]) + 1'b1)));
         end
      end
   endgenerate
endmodule

bind stat_bank stat_bank_chk #(
   .NUM_CNT  (NUM_CNT),
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .SATURATE (SATURATE),
   .REV_ID   (REV_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_pulse (evt_pulse),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .live_flat (live_flat),
   .snap_flat (snap_flat),
   .freeze    (freeze)
);

// File: tb/tb_stat_bank.sv
module tb_stat_bank;
   localparam int unsigned NC  = 4;
   localparam int unsigned CW  = 8;
   localparam int unsigned AW  = 3;
   localparam int unsigned DW  = 32;
   localparam logic [31:0] REV = 32'h5A17_0003;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] evt_pulse = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int exp_live [NC];
   int exp_snap [NC];
   bit frozen = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stat_bank #(
      .NUM_CNT (NC), .CNT_W (CW), .ADDR_W (AW), .DATA_W (DW),
      .SATURATE (1'b0), .REV_ID (REV)
   ) dut (
      .clk (clk), .rst_n (rst_n), .evt_pulse (evt_pulse), .wr_en (wr_en),
      .rd_en (rd_en), .addr (addr), .wr_data (wr_data), .rd_data (rd_data)
   );

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [NC-1:0] m);
      evt_pulse = m;
      @(negedge clk);
      evt_pulse = '0;
      for (int i = 0; i < NC; i++) if (m[i]) exp_live[i] = (exp_live[i] + 1) % (1 << CW);
   endtask

   // Counter reads compared with the live or frozen model
   task automatic check_counters(input string tag);
      logic [DW-1:0] d;
      for (int i = 0; i < NC; i++) begin
         rd(3 + i, d);
         check(tag, d, DW'(frozen ? exp_snap[i] : exp_live[i]));
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [DW-1:0] d;
      for (int i = 0; i < NC; i++) begin exp_live[i] = 0; exp_snap[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(2, d); check("R1 cmd", d, 0);
      rd(1, d); check("R1 scratch", d, 0);
      check_counters("R1 counters");

      // R2: revision word, write ignored
      rd(0, d); check("R2 rev", d, REV);
      wr(0, 32'hFFFF_FFFF);
      rd(0, d); check("R2 rev after write", d, REV);

      // R3: scratch patterns
      foreach (exp_snap[k]) begin
         logic [DW-1:0] pat;
         pat = 32'hA5A5_5A5A ^ (32'h1111_1111 * k) ^ {32{k[0]}};
         wr(1, pat);
         rd(1, d); check("R3 scratch", d, pat);
      end

      // R4, R13: every event mask, with counter reads after each
      for (int m = 0; m < (1 << NC); m++) begin
         pulse(NC'(m));
         check_counters("R4 sweep");
      end
      // R13: the read data holds when there is no read
      rd(3, d);
      @(negedge clk);
      check("R13 hold", rd_data, DW'(exp_live[0]));

      // R11: counter writes ignored, unused address reads 0
      wr(4, 32'h77);
      check_counters("R11 counter write ignored");
      rd(7, d); check("R11 unused addr", d, 0);

      // R5: wrap of counter 0 after 2^CW steps
      for (int n = 0; n < 300; n++) pulse(NC'(1));
      check_counters("R5 wrap");

      // R6: clear, bit reads back 0
      wr(2, 32'h8);
      for (int i = 0; i < NC; i++) exp_live[i] = 0;
      rd(2, d); check("R6 cmd self-clear", d, 0);
      check_counters("R6 cleared");

      // R7: clear together with events
      pulse('1); pulse(NC'(5));
      evt_pulse = '1; wr_en = 1'b1; addr = AW'(2); wr_data = 32'h8;
      @(negedge clk);
      evt_pulse = '0; wr_en = 1'b0;
      for (int i = 0; i < NC; i++) exp_live[i] = 0;
      check_counters("R7 clear beats event");

      // R8: freeze, live keeps counting, repeated freeze does not recapture
      pulse(NC'(3)); pulse(NC'(6)); pulse(NC'(9));
      wr(2, 32'h4);
      frozen = 1'b1;
      for (int i = 0; i < NC; i++) exp_snap[i] = exp_live[i];
      rd(2, d); check("R12 cmd freeze readback", d, 32'h4);
      pulse('1); pulse(NC'(2));
      check_counters("R8 frozen view");
      wr(2, 32'h4);
      pulse('1);
      check_counters("R8 no recapture");

      // R9: release shows live values
      wr(2, 32'h0);
      frozen = 1'b0;
      check_counters("R9 released");

      // R10: clear while frozen zeroes the copies
      wr(2, 32'h4);
      frozen = 1'b1;
      for (int i = 0; i < NC; i++) exp_snap[i] = exp_live[i];
      pulse('1);
      wr(2, 32'hC);
      for (int i = 0; i < NC; i++) begin exp_live[i] = 0; exp_snap[i] = 0; end
      check_counters("R10 copies cleared");
      pulse(NC'(2)); pulse(NC'(2)); pulse(NC'(2));
      check_counters("R10 frozen after clear");
      wr(2, 32'h0);
      frozen = 1'b0;
      check_counters("R10 live after release");

      // R12: other command bits do not stick (all-ones write also clears)
      wr(2, 32'hFFFF_FFFF);
      for (int i = 0; i < NC; i++) begin exp_live[i] = 0; exp_snap[i] = 0; end
      frozen = 1'b1;
      rd(2, d); check("R12 only freeze bit", d, 32'h4);
      check_counters("R12 frozen zero");
      wr(2, 32'h0);
      frozen = 1'b0;
      rd(2, d); check("R12 cmd zero", d, 0);

      done = 1'b1;
      finish_run();
   end
endmodule